// File: doc/BRIEF.md
# Memory Refresh Mode Controller

This block holds the mode and control state for one external memory area that may be populated with dynamic RAM or pseudo-static RAM. When no RAM type is chosen, the area's refresh timer is left to software as a general interval timer. A two-bit memory-type field in the refresh control register selects among these uses. From that field the block derives the bus-cycle length for the area, whether wait states may be inserted, and whether a self-refresh request is raised while the chip sits in software standby.

Once a RAM type is active, the refresh timer registers and the low control bits of the refresh control register ignore writes, so refresh timing cannot be disturbed by accident. The compare-match flag of the timer stays clearable by a write of zero. The timer counter datapath, row/column sequencing and address multiplexing live in other blocks. This block only stores the timer's control, counter and constant values and reports the selected mode.

Registers sit behind a single-cycle synchronous port. Writes take effect at the clock edge that samples them, and read data is a combinational function of the address.

Top module: `memref_mode_ctl`

## Requirements
- R1: After reset, all four registers read 0x00, `selfref_req`, `dram_sel`, `psram_sel`, `type_err` and `three_state_cyc` are 0, and `wait_ok` is 1.
- R2: The memory-type field is bits 6:5 of the refresh control register (address 0). Value 01 selects dynamic RAM (`dram_sel`=1), 10 selects pseudo-static RAM (`psram_sel`=1), and 00 selects interval-timer use, with neither output set.
- R3: The value 11 in the memory-type field is stored and read back as written. It sets `type_err`, selects no RAM type, never raises `selfref_req` and leaves every register writable.
- R4: While the stored type is 01 or 10, writes leave unchanged bits 0, 2, 3 and 4 of the refresh control register, bits 6:0 of the timer control/status register (address 1), the timer counter register (address 2) and the timer constant register (address 3). Bits 7, 6, 5 and 1 of the refresh control register stay writable.
- R5: The compare-match flag is bit 7 of the timer control/status register. Writing 0 to it clears it, locked or not, and writing 1 to it leaves it unchanged.
- R6: A high `cmp_match` sets the compare-match flag at the next edge, and this wins over a write-0 clear in the same cycle.
- R7: `selfref_req` rises at the edge sampling `stby_enter` only when refresh control bit 7 (self-refresh enable) is 1 and the stored type is 01 or 10. It falls at the edge sampling `stby_exit`, and when both pulses arrive together `stby_exit` wins.
- R8: `three_state_cyc` is 1 exactly when the type field selects 01 or 10.
- R9: `wait_ok` is 0 exactly when a RAM type is selected and `area_ast` sampled at the same edge is 0. Otherwise it is 1.
- R10: A register write and the mode outputs it implies take effect at the same edge, and `reg_rdata` shows the addressed register in the same cycle, under any mix of writes, pulses and standby events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 refresh control, 1 timer control/status, 2 timer counter, 3 timer constant |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| cmp_match | input | 1 | Compare-match pulse from the timer |
| stby_enter | input | 1 | Software standby entry pulse |
| stby_exit | input | 1 | Software standby exit pulse |
| area_ast | input | 1 | Access-state bit of the memory area |
| selfref_req | output | 1 | Self-refresh request to the memory |
| dram_sel | output | 1 | Dynamic RAM selected |
| psram_sel | output | 1 | Pseudo-static RAM selected |
| type_err | output | 1 | Illegal memory-type code stored |
| three_state_cyc | output | 1 | Area cycles forced to three states |
| wait_ok | output | 1 | Wait-state insertion permitted |

## Verification
The hardest cases to reach are the ones where two events fall in the same cycle: a compare-match pulse on the cycle of a write-0 clear, and standby entry together with standby exit. The directed stimulus places these pairs on one clock on purpose, each with the self-refresh enable and type field first set to the value that makes the outcome visible. A locked write to the refresh control register that flips both locked and free bits shows the per-bit mask only when the register is read back afterwards. The bench therefore follows each locked write with reads of all four addresses, and then runs a long random phase that a behavioural model checks on every clock.

// File: rtl/memref_pkg.sv
package memref_pkg;

    typedef enum logic [1:0] {
        MT_TIMER = 2'b00,
        MT_DRAM  = 2'b01,
        MT_PSRAM = 2'b10,
        MT_BAD   = 2'b11
    } mem_type_e;

    typedef enum logic [1:0] {
        RA_RCTL   = 2'd0,
        RA_TCSR   = 2'd1,
        RA_TCNT   = 2'd2,
        RA_TCONST = 2'd3
    } reg_addr_e;

    // field positions inside the refresh control register
    localparam int TYPE_LSB   = 5;
    localparam int SREN_BIT   = 7;

    typedef struct packed {
        logic dram;
        logic psram;
        logic err;
        logic three;
        logic wait_ok;
    } mode_t;

    localparam mode_t MODE_RST = '{dram: 1'b0, psram: 1'b0, err: 1'b0,
                                   three: 1'b0, wait_ok: 1'b1};

    function automatic logic is_ram(input mem_type_e t);
        return (t == MT_DRAM) || (t == MT_PSRAM);
    endfunction

    function automatic mode_t decode_mode(input mem_type_e t, input logic ast);
        mode_t m;
        m.dram    = (t == MT_DRAM);
        m.psram   = (t == MT_PSRAM);
        m.err     = (t == MT_BAD);
        m.three   = is_ram(t);
        m.wait_ok = !(is_ram(t) && !ast);
        return m;
    endfunction

endpackage

// File: rtl/memref_regfile.sv
module memref_regfile
    import memref_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter int          ADDR_W     = 2,
    parameter logic [7:0]  LOCK_MASK  = 8'h1D,
    parameter logic [7:0]  TCONST_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmp_match,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] rctl_q,
    output logic [DATA_W-1:0] rctl_d,
    output logic [DATA_W-1:0] tcsr_q,
    output logic [DATA_W-1:0] tcnt_q,
    output logic [DATA_W-1:0] tconst_q
);
    localparam int FLAG_BIT = DATA_W - 1;

    logic locked;
    logic sel_rctl, sel_tcsr, sel_tcnt, sel_tconst;
    logic [DATA_W-1:0] tcsr_d, tcnt_d, tconst_d;

    assign locked     = is_ram(mem_type_e'(rctl_q[TYPE_LSB +: 2]));
    assign sel_rctl   = we && (addr == ADDR_W'(RA_RCTL));
    assign sel_tcsr   = we && (addr == ADDR_W'(RA_TCSR));
    assign sel_tcnt   = we && (addr == ADDR_W'(RA_TCNT));
    assign sel_tconst = we && (addr == ADDR_W'(RA_TCONST));

    // per-bit write enable of the refresh control register
    for (genvar i = 0; i < DATA_W; i++) begin : g_rctl_bit
        if (LOCK_MASK[i]) begin : g_lockable
            assign rctl_d[i] = (sel_rctl && !locked) ? wdata[i] : rctl_q[i];
        end else begin : g_free
            assign rctl_d[i] = sel_rctl ? wdata[i] : rctl_q[i];
        end
    end

    always_comb begin
        tcsr_d[FLAG_BIT-1:0] = (sel_tcsr && !locked) ? wdata[FLAG_BIT-1:0]
                                                      : tcsr_q[FLAG_BIT-1:0];
        // set pulse dominates a write-0 clear; write-1 keeps the flag
        tcsr_d[FLAG_BIT] = cmp_match ||
                           (tcsr_q[FLAG_BIT] && !(sel_tcsr && !wdata[FLAG_BIT]));
        tcnt_d   = (sel_tcnt   && !locked) ? wdata : tcnt_q;
        tconst_d = (sel_tconst && !locked) ? wdata : tconst_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rctl_q   <= '0;
            tcsr_q   <= '0;
            tcnt_q   <= '0;
            tconst_q <= DATA_W'(TCONST_RST);
        end else begin
            rctl_q   <= rctl_d;
            tcsr_q   <= tcsr_d;
            tcnt_q   <= tcnt_d;
            tconst_q <= tconst_d;
        end
    end

    always_comb begin
        unique case (reg_addr_e'(addr))
            RA_RCTL:   rdata = rctl_q;
            RA_TCSR:   rdata = tcsr_q;
            RA_TCNT:   rdata = tcnt_q;
            RA_TCONST: rdata = tconst_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/memref_mode_dec.sv
module memref_mode_dec
    import memref_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] type_nx,
    input  logic       ast,
    output mode_t      mode_q
);
    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RST;
        else     mode_q <= decode_mode(mem_type_e'(type_nx), ast);
    end
endmodule

// File: rtl/memref_sref.sv
module memref_sref
    import memref_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enter,
    input  logic       leave,
    input  logic       sren,
    input  logic [1:0] type_q,
    output logic       req
);
    always_ff @(posedge clk) begin
        if (rst)
            req <= 1'b0;
        else if (leave)
            req <= 1'b0;
        else if (enter && sren && is_ram(mem_type_e'(type_q)))
            req <= 1'b1;
    end
endmodule

// File: rtl/memref_mode_ctl.sv
module memref_mode_ctl
    import memref_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter int         ADDR_W     = 2,
    parameter logic [7:0] LOCK_MASK  = 8'h1D,
    parameter logic [7:0] TCONST_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cmp_match,
    input  logic              stby_enter,
    input  logic              stby_exit,
    input  logic              area_ast,
    output logic              selfref_req,
    output logic              dram_sel,
    output logic              psram_sel,
    output logic              type_err,
    output logic              three_state_cyc,
    output logic              wait_ok
);
    logic [DATA_W-1:0] rctl_q, rctl_d, tcsr_q, tcnt_q, tconst_q;
    mode_t             mode_q;

    memref_regfile #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .LOCK_MASK(LOCK_MASK), .TCONST_RST(TCONST_RST)
    ) rf_i (
        .clk(clk), .rst(rst), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
        .cmp_match(cmp_match), .rdata(reg_rdata), .rctl_q(rctl_q),
        .rctl_d(rctl_d), .tcsr_q(tcsr_q), .tcnt_q(tcnt_q), .tconst_q(tconst_q)
    );

    memref_mode_dec dec_i (
        .clk(clk), .rst(rst), .type_nx(rctl_d[TYPE_LSB +: 2]),
        .ast(area_ast), .mode_q(mode_q)
    );

    memref_sref sref_i (
        .clk(clk), .rst(rst), .enter(stby_enter), .leave(stby_exit),
        .sren(rctl_q[SREN_BIT]), .type_q(rctl_q[TYPE_LSB +: 2]),
        .req(selfref_req)
    );

    assign dram_sel        = mode_q.dram;
    assign psram_sel       = mode_q.psram;
    assign type_err        = mode_q.err;
    assign three_state_cyc = mode_q.three;
    assign wait_ok         = mode_q.wait_ok;

endmodule

// File: rtl/memref_mode_ctl_chk.sv
module memref_mode_ctl_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              cmp_match,
    input logic              stby_enter,
    input logic              stby_exit,
    input logic              selfref_req,
    input logic              dram_sel,
    input logic              psram_sel,
    input logic              type_err,
    input logic              three_state_cyc,
    input logic              wait_ok,
    input logic [DATA_W-1:0] tcsr_q,
    input logic [DATA_W-1:0] tcnt_q
);
    assert_type_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dram_sel, psram_sel, type_err}));

    // R3: illegal code never selects a RAM type
    assert_bad_no_ram_R3: assert property (@(posedge clk) disable iff (rst)
        type_err |-> !three_state_cyc);

    assert_cnt_locked_R4: assert property (@(posedge clk) disable iff (rst)
        ((dram_sel || psram_sel) && reg_we && reg_addr == ADDR_W'(2))
        |=> $stable(tcnt_q));

    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(1) && !reg_wdata[DATA_W-1] && !cmp_match)
        |=> !tcsr_q[DATA_W-1]);

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
        cmp_match |=> tcsr_q[DATA_W-1]);

    assert_sref_exit_R7: assert property (@(posedge clk) disable iff (rst)
        stby_exit |=> !selfref_req);

    assert_sref_rise_R7: assert property (@(posedge clk) disable iff (rst)
        !stby_enter |=> !$rose(selfref_req));

    assert_three_state_R8: assert property (@(posedge clk) disable iff (rst)
        three_state_cyc == (dram_sel || psram_sel));

    assert_wait_ram_R9: assert property (@(posedge clk) disable iff (rst)
        !wait_ok |-> three_state_cyc);
endmodule

bind memref_mode_ctl memref_mode_ctl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/memref_mode_ctl_tb.sv
`timescale 1ns/1ps
module memref_mode_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cmp_match = 1'b0, stby_enter = 1'b0, stby_exit = 1'b0;
    logic       area_ast = 1'b0;
    logic       selfref_req, dram_sel, psram_sel, type_err, three_state_cyc, wait_ok;

    always #10 clk = ~clk;   // 50 MHz

    memref_mode_ctl dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_match(cmp_match),
        .stby_enter(stby_enter), .stby_exit(stby_exit), .area_ast(area_ast),
        .selfref_req(selfref_req), .dram_sel(dram_sel), .psram_sel(psram_sel),
        .type_err(type_err), .three_state_cyc(three_state_cyc), .wait_ok(wait_ok)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference state
    logic [7:0] m_reg [4];
    logic       m_sr;
    logic       m_wait;

    function automatic bit m_ram(input logic [7:0] ctl);
        return (ctl[6:5] == 2'd1) || (ctl[6:5] == 2'd2);
    endfunction

    task automatic model_edge(input logic [1:0] a, input logic we, input logic [7:0] wd,
                              input logic cm, input logic en, input logic ex,
                              input logic ast);
        bit lk;
        bit can_sr;
        logic [7:0] nxt;
        lk     = m_ram(m_reg[0]);
        can_sr = m_reg[0][7] && lk;
        if (we) begin
            if (a == 2'd0)
                m_reg[0] = lk ? ((wd & 8'hE2) | (m_reg[0] & 8'h1D)) : wd;
            else if (a == 2'd1) begin
                nxt = m_reg[1];
                if (!lk) nxt[6:0] = wd[6:0];
                if (!wd[7]) nxt[7] = 1'b0;
                m_reg[1] = nxt;
            end else if (!lk)
                m_reg[a] = wd;
        end
        if (cm) m_reg[1][7] = 1'b1;
        if (ex) m_sr = 1'b0;
        else if (en && can_sr) m_sr = 1'b1;
        m_wait = !(m_ram(m_reg[0]) && !ast);
    endtask

    task automatic compare(input logic [1:0] a);
        logic [13:0] act, exp;
        act = {reg_rdata, selfref_req, dram_sel, psram_sel, type_err, three_state_cyc, wait_ok};
        exp = {m_reg[a], m_sr, m_reg[0][6:5] == 2'd1, m_reg[0][6:5] == 2'd2,
               m_reg[0][6:5] == 2'd3, m_ram(m_reg[0]), m_wait};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h (rdata,sr,dram,psram,err,three,wait)",
                     cur_req, a, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] a, input logic we, input logic [7:0] wd,
                        input logic cm, input logic en, input logic ex, input logic ast);
        reg_addr = a; reg_we = we; reg_wdata = wd;
        cmp_match = cm; stby_enter = en; stby_exit = ex; area_ast = ast;
        @(posedge clk);
        model_edge(a, we, wd, cm, en, ex, ast);
        #5;
        compare(a);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        step(a, 1'b1, d, 1'b0, 1'b0, 1'b0, area_ast);
    endtask

    task automatic rd(input logic [1:0] a);
        step(a, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, area_ast);
    endtask

    task automatic rd_all();
        for (int k = 0; k < 4; k++) rd(2'(k));
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired during %s", cur_req);
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) m_reg[k] = 8'h00;
        m_sr = 1'b0; m_wait = 1'b1;
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        // R1 reset state
        cur_req = "R1";
        compare(2'd0);
        rd_all();

        // R2 type encoding
        cur_req = "R2";
        wr(2'd0, 8'h20); rd(2'd0);
        wr(2'd0, 8'h40); rd(2'd0);
        wr(2'd0, 8'h00);

        // R3 illegal code: stored, error, unlocked
        cur_req = "R3";
        wr(2'd0, 8'h7D);
        wr(2'd2, 8'h55); wr(2'd3, 8'h66); wr(2'd1, 8'h3C);
        rd_all();
        wr(2'd0, 8'hE0);
        step(2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);

        // R4 lock with dynamic RAM, then pseudo-static RAM
        cur_req = "R4";
        wr(2'd0, 8'h20);
        wr(2'd2, 8'hAA); wr(2'd3, 8'hBB); wr(2'd1, 8'h7F);
        wr(2'd0, 8'h3F);
        rd_all();
        wr(2'd0, 8'h40);
        wr(2'd2, 8'h11); wr(2'd0, 8'h5D);
        rd_all();
        wr(2'd0, 8'h00); wr(2'd2, 8'h12); rd(2'd2);

        // R5 flag clear by 0, no effect by 1, also while locked
        cur_req = "R5";
        step(2'd1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        wr(2'd1, 8'h80); rd(2'd1);
        wr(2'd1, 8'h00); rd(2'd1);
        wr(2'd0, 8'h20);
        step(2'd1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        wr(2'd1, 8'h7F); rd(2'd1);

        // R6 set beats clear
        cur_req = "R6";
        step(2'd1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        rd(2'd1);

        // R7 standby self-refresh
        cur_req = "R7";
        wr(2'd0, 8'hA0);
        step(2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        rd(2'd0);
        step(2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        step(2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        wr(2'd0, 8'hC0);
        step(2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        step(2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        wr(2'd0, 8'h80);
        step(2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        wr(2'd0, 8'h40);
        step(2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);

        // R8 / R9 three-state and wait permission
        cur_req = "R8";
        wr(2'd0, 8'h20); wr(2'd0, 8'h00); wr(2'd0, 8'h40);
        cur_req = "R9";
        step(2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        step(2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        step(2'd0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        step(2'd0, 1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 1'b1);

        // R10 random mix
        cur_req = "R10";
        for (int n = 0; n < 600; n++) begin
            logic [7:0] d;
            d = 8'($urandom);
            step(2'($urandom), ($urandom % 2) == 0, d,
                 ($urandom % 8) == 0, ($urandom % 6) == 0,
                 ($urandom % 8) == 0, ($urandom % 4) != 0);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule